// File: doc/BRIEF.md
# Pushed Compare Transfer Sequencer

This block sits behind the access-port data path of a debug port. A single transaction from the serial link engine becomes a burst of target-side accesses that runs at system clock speed, with no further traffic on the link. A programmable count sets the burst length, and an address register advances by one data word after each completed access. A debugger can therefore fill a block of memory by writing the start address once and then sending the data word.

In the two pushed modes, the word that the link delivers as a write is used as a reference value instead of being written to the target. Each target access becomes a read. The returned data and the reference are both masked and then compared. Verify mode stops on the first mismatch and find mode stops on the first match. In either case the sticky flag is set, the address register keeps the address that caused the stop, and the remaining count is frozen. If no stop occurs, the address register ends one word past the block.

While a burst runs, a busy output tells the link engine to answer WAIT. While the sticky flag is set, new access requests are taken and then discarded until software clears the flag.

Top module: `push_cmp_seq`

## Requirements
- R1: After reset, the sticky flag, busy, target request, mode, mask, count and address are all zero.
- R2: Register index 0 holds the mode in bits [1:0] (writable) and reads back sticky in bit 2 and busy in bit 3. Index 1 is the mask, index 2 the count and index 3 the address. Register writes are ignored while busy and in the cycle an access is accepted.
- R3: An accepted access runs `count` target accesses when count is nonzero and exactly one when it is zero. Count decrements per completed access and reaches zero at the end of an untriggered burst.
- R4: The address advances by DW/8 after every completed access that does not trigger. In normal mode, N consecutive words are written with one address write and one data write.
- R5: The target request, address, write flag and write data stay stable until the target acknowledges.
- R6: In normal mode a read request performs one target read, and its data appears on `ap_rdata`.
- R7: In mode 2'b01 (verify) and mode 2'b10 (find), an access-port write produces target reads only, never a target write, and compares (rdata & mask) with (reference & mask). Mode 2'b11 behaves as normal mode.
- R8: Verify triggers on a masked mismatch. Find triggers on a masked match. A trigger sets sticky.
- R9: On a trigger the burst stops at once. The address register holds the triggering address and count holds the value it had for that access.
- R10: `ap_busy` is high from the cycle after acceptance until the burst ends.
- R11: While sticky is set, access requests cause no target access and no register change. Writing bit 2 = 1 to index 0 clears sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register index |
| csr_wdata | input | DW | Register write data |
| csr_rdata | output | DW | Register read data (combinational) |
| ap_req | input | 1 | Access request from link engine |
| ap_wr | input | 1 | Request is a write |
| ap_wdata | input | DW | Write data or compare reference |
| ap_rdata | output | DW | Data of last normal read |
| ap_busy | output | 1 | Burst in progress (link answers WAIT) |
| tgt_req | output | 1 | Target access request |
| tgt_wr | output | 1 | Target access is a write |
| tgt_addr | output | AW | Target address |
| tgt_wdata | output | DW | Target write data |
| tgt_ack | input | 1 | Target completes access |
| tgt_rdata | input | DW | Target read data |
| sticky | output | 1 | Compare trigger flag |

## Verification
The hardest state to reach from the ports is a trigger in the middle of a burst, where the frozen count and the held address must both be exact. The bench's target returns data computed from the address, so each vector can place a match or a mismatch at a chosen word of a multi-word burst and predict the address and count at the stop. A second hard case is a request that arrives while sticky is set and must have no effect at all. The bench reaches it by provoking a trigger, switching to normal mode without clearing sticky, and then confirming that the target write count and the address register are unchanged.

// File: rtl/push_cmp_pkg.sv
package push_cmp_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_VERIFY = 2'b01,
        MODE_FIND   = 2'b10,
        MODE_RSVD   = 2'b11
    } xfer_mode_e;

    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_MASK  = 2'd1;
    localparam logic [1:0] REG_COUNT = 2'd2;
    localparam logic [1:0] REG_ADDR  = 2'd3;

    localparam int CTRL_STICKY_BIT = 2;
    localparam int CTRL_BUSY_BIT   = 3;

    function automatic logic mode_is_pushed(input logic [1:0] m);
        return (m == MODE_VERIFY) || (m == MODE_FIND);
    endfunction
endpackage

// File: rtl/push_cmp_unit.sv
module push_cmp_unit #(
    parameter int DW = 32
) (
    input  logic          en,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] refv,
    input  logic [DW-1:0] rdata,
    output logic          trig
);
    import push_cmp_pkg::*;

    logic [DW-1:0] diff;
    logic          equal;

    always_comb begin
        diff  = (rdata ^ refv) & mask;
        equal = (diff == '0);
        trig  = 1'b0;
        if (en) begin
            unique case (mode)
                MODE_VERIFY: trig = !equal;
                MODE_FIND:   trig = equal;
                default:     trig = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/push_cmp_rdmux.sv
module push_cmp_rdmux #(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic [1:0]    sel,
    input  logic [1:0]    mode,
    input  logic          sticky,
    input  logic          busy,
    input  logic [DW-1:0] mask,
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rdata
);
    import push_cmp_pkg::*;

    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_CTRL: begin
                rdata[1:0]             = mode;
                rdata[CTRL_STICKY_BIT] = sticky;
                rdata[CTRL_BUSY_BIT]   = busy;
            end
            REG_MASK:  rdata = mask;
            REG_COUNT: rdata = DW'(cnt);
            default:   rdata = DW'(addr);
        endcase
    end
endmodule

// File: rtl/push_cmp_seq.sv
module push_cmp_seq #(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_we,
    input  logic [1:0]    csr_addr,
    input  logic [DW-1:0] csr_wdata,
    output logic [DW-1:0] csr_rdata,
    input  logic          ap_req,
    input  logic          ap_wr,
    input  logic [DW-1:0] ap_wdata,
    output logic [DW-1:0] ap_rdata,
    output logic          ap_busy,
    output logic          tgt_req,
    output logic          tgt_wr,
    output logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_wdata,
    input  logic          tgt_ack,
    input  logic [DW-1:0] tgt_rdata,
    output logic          sticky
);
    import push_cmp_pkg::*;

    localparam int STEP = DW / 8;

    typedef struct packed {
        logic          busy;
        logic          sticky;
        logic [1:0]    mode;
        logic [DW-1:0] mask;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] refv;
        logic          wr;
        logic          push;
        logic [DW-1:0] rd;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       accept;
    logic       trig;

    push_cmp_unit #(.DW(DW)) u_cmp (
        .en    (st_q.push),
        .mode  (st_q.mode),
        .mask  (st_q.mask),
        .refv  (st_q.refv),
        .rdata (tgt_rdata),
        .trig  (trig)
    );

    push_cmp_rdmux #(.DW(DW), .AW(AW), .CW(CW)) u_rdmux (
        .sel    (csr_addr),
        .mode   (st_q.mode),
        .sticky (st_q.sticky),
        .busy   (st_q.busy),
        .mask   (st_q.mask),
        .cnt    (st_q.cnt),
        .addr   (st_q.addr),
        .rdata  (csr_rdata)
    );

    always_comb begin
        st_d   = st_q;
        accept = ap_req && !st_q.busy && !st_q.sticky;

        // register writes only while idle and no access starts
        if (csr_we && !st_q.busy && !accept) begin
            unique case (csr_addr)
                REG_CTRL: begin
                    st_d.mode = csr_wdata[1:0];
                    if (csr_wdata[CTRL_STICKY_BIT]) st_d.sticky = 1'b0;
                end
                REG_MASK:  st_d.mask = csr_wdata;
                REG_COUNT: st_d.cnt  = csr_wdata[CW-1:0];
                default:   st_d.addr = csr_wdata[AW-1:0];
            endcase
        end

        if (accept) begin
            st_d.busy = 1'b1;
            st_d.refv = ap_wdata;
            st_d.push = ap_wr && mode_is_pushed(st_q.mode);
            st_d.wr   = ap_wr && !mode_is_pushed(st_q.mode);
        end

        if (st_q.busy && tgt_ack) begin
            if (trig) begin
                st_d.busy   = 1'b0;
                st_d.sticky = 1'b1;
            end else begin
                st_d.addr = st_q.addr + AW'(STEP);
                if (!st_q.wr && !st_q.push) st_d.rd = tgt_rdata;
                if (st_q.cnt > CW'(1)) begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end else begin
                    st_d.cnt  = '0;
                    st_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ap_busy   = st_q.busy;
    assign ap_rdata  = st_q.rd;
    assign tgt_req   = st_q.busy;
    assign tgt_wr    = st_q.wr;
    assign tgt_addr  = st_q.addr;
    assign tgt_wdata = st_q.refv;
    assign sticky    = st_q.sticky;
endmodule

// File: rtl/push_cmp_seq_chk.sv
module push_cmp_seq_chk #(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          csr_we,
    input logic [1:0]    csr_addr,
    input logic [DW-1:0] csr_wdata,
    input logic          ap_busy,
    input logic          tgt_req,
    input logic          tgt_wr,
    input logic [AW-1:0] tgt_addr,
    input logic [DW-1:0] tgt_wdata,
    input logic          tgt_ack,
    input logic          sticky
);
    localparam int STEP = DW / 8;

    // R5
    tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_ack) |=> (tgt_req && $stable(tgt_addr) && $stable(tgt_wr) && $stable(tgt_wdata)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tgt_req && tgt_ack) && tgt_req) |-> (tgt_addr == $past(tgt_addr) + AW'(STEP)));

    // R8
    trig_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky) |-> $past(tgt_req && tgt_ack && !tgt_wr));

    // R9
    trig_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky) |-> !ap_busy);

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !(csr_we && csr_addr == 2'd0 && csr_wdata[2])) |=> sticky);

    // R11
    sticky_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !ap_busy) |=> !tgt_req);
endmodule

bind push_cmp_seq push_cmp_seq_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .ap_busy   (ap_busy),
    .tgt_req   (tgt_req),
    .tgt_wr    (tgt_wr),
    .tgt_addr  (tgt_addr),
    .tgt_wdata (tgt_wdata),
    .tgt_ack   (tgt_ack),
    .sticky    (sticky)
);

// File: tb/push_cmp_seq_test.sv
module push_cmp_seq_test;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 1'b0;
    logic [1:0]    csr_addr = 2'd0;
    logic [DW-1:0] csr_wdata = '0;
    logic [DW-1:0] csr_rdata;
    logic          ap_req = 1'b0;
    logic          ap_wr = 1'b0;
    logic [DW-1:0] ap_wdata = '0;
    logic [DW-1:0] ap_rdata;
    logic          ap_busy;
    logic          tgt_req;
    logic          tgt_wr;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_wdata;
    logic          tgt_ack;
    logic [DW-1:0] tgt_rdata;
    logic          sticky;
    logic          ack_en = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int wcnt = 0;
    int rcnt = 0;
    logic [31:0] wmem [64];

    always #2.5 clk = ~clk;

    // target model: zero-wait unless stalled, data derived from address
    assign tgt_ack   = tgt_req && ack_en;
    assign tgt_rdata = 32'hA5A5_0000 | {16'h0, tgt_addr[15:0]};

    always @(posedge clk) begin
        if (tgt_req && tgt_ack) begin
            if (tgt_wr) begin
                wmem[tgt_addr[7:2]] <= tgt_wdata;
                wcnt <= wcnt + 1;
            end else begin
                rcnt <= rcnt + 1;
            end
        end
    end

    push_cmp_seq #(.DW(DW), .AW(AW), .CW(CW)) uut (.*);

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] mask;
        logic [15:0] cnt;
        logic [31:0] addr;
        logic [31:0] refv;
        logic        stk;
        logic [31:0] eaddr;
        logic [15:0] ecnt;
        logic [15:0] ereads;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{2'b01, 32'hFFFF_0000, 16'd4, 32'h10,  32'hA5A5_0000, 1'b0, 32'h20,  16'd0, 16'd4},
        '{2'b01, 32'hFFFF_FFFF, 16'd4, 32'h10,  32'hA5A5_0018, 1'b1, 32'h10,  16'd4, 16'd1},
        '{2'b10, 32'hFFFF_FFFF, 16'd8, 32'h10,  32'hA5A5_001C, 1'b1, 32'h1C,  16'd5, 16'd4},
        '{2'b10, 32'h0000_000F, 16'd6, 32'h0,   32'h0000_0008, 1'b1, 32'h8,   16'd4, 16'd3},
        '{2'b01, 32'h0000_FF00, 16'd3, 32'h100, 32'h0000_0000, 1'b1, 32'h100, 16'd3, 16'd1},
        '{2'b10, 32'hFFFF_FFFF, 16'd3, 32'h40,  32'h0000_0000, 1'b0, 32'h4C,  16'd0, 16'd3},
        '{2'b01, 32'hFFFF_FFFF, 16'd0, 32'h30,  32'hA5A5_0030, 1'b0, 32'h34,  16'd0, 16'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [1:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic ap_start(input logic wr, input logic [31:0] d);
        @(negedge clk);
        ap_req = 1'b1; ap_wr = wr; ap_wdata = d;
        @(negedge clk);
        ap_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (ap_busy) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int r0;
        int w0;

        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 sticky", {31'h0, sticky}, 32'h0);
        chk("R1 busy", {31'h0, ap_busy}, 32'h0);
        chk("R1 tgt_req", {31'h0, tgt_req}, 32'h0);
        csr_rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
        csr_rd(2'd1, v); chk("R1 mask", v, 32'h0);
        csr_rd(2'd2, v); chk("R1 count", v, 32'h0);
        csr_rd(2'd3, v); chk("R1 addr", v, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 register map read back
        csr_wr(2'd0, 32'h2);
        csr_wr(2'd1, 32'h1234_5678);
        csr_rd(2'd0, v); chk("R2 mode readback", v, 32'h2);
        csr_rd(2'd1, v); chk("R2 mask readback", v, 32'h1234_5678);

        // vector table: pushed verify/find (R3 R7 R8 R9)
        for (int i = 0; i < NV; i++) begin
            csr_wr(2'd0, {30'h0, VT[i].mode});
            csr_wr(2'd1, VT[i].mask);
            csr_wr(2'd2, {16'h0, VT[i].cnt});
            csr_wr(2'd3, VT[i].addr);
            r0 = rcnt;
            w0 = wcnt;
            ap_start(1'b1, VT[i].refv);
            wait_idle();
            chk("R8 sticky", {31'h0, sticky}, {31'h0, VT[i].stk});
            csr_rd(2'd3, v); chk("R9 R4 address", v, VT[i].eaddr);
            csr_rd(2'd2, v); chk("R9 R3 count", v, {16'h0, VT[i].ecnt});
            chk("R3 target reads", rcnt - r0, {16'h0, VT[i].ereads});
            chk("R7 no target write", wcnt - w0, 32'h0);
            csr_wr(2'd0, 32'h4);
            chk("R11 sticky cleared", {31'h0, sticky}, 32'h0);
        end

        // R4 R10 R2: normal write burst, busy visible, register write ignored while busy
        csr_wr(2'd0, 32'h0);
        csr_wr(2'd2, 32'd3);
        csr_wr(2'd3, 32'h200);
        w0 = wcnt;
        @(negedge clk);
        ap_req = 1'b1; ap_wr = 1'b1; ap_wdata = 32'hCAFE_0001;
        @(negedge clk);
        ap_req = 1'b0;
        chk("R10 busy during burst", {31'h0, ap_busy}, 32'h1);
        csr_we = 1'b1; csr_addr = 2'd3; csr_wdata = 32'h999;
        @(negedge clk);
        csr_we = 1'b0;
        wait_idle();
        csr_rd(2'd3, v); chk("R2 write ignored while busy", v, 32'h20C);
        chk("R4 words written", wcnt - w0, 32'd3);
        chk("R4 word0", wmem[0], 32'hCAFE_0001);
        chk("R4 word2", wmem[2], 32'hCAFE_0001);
        chk("R10 busy dropped", {31'h0, ap_busy}, 32'h0);

        // R6 normal read, count zero gives one access
        csr_wr(2'd2, 32'd0);
        csr_wr(2'd3, 32'h44);
        r0 = rcnt;
        ap_start(1'b0, 32'h0);
        wait_idle();
        chk("R6 read data", ap_rdata, 32'hA5A5_0044);
        chk("R3 single access", rcnt - r0, 32'd1);

        // R7 reserved mode 2'b11 acts as normal write
        csr_wr(2'd0, 32'h3);
        csr_wr(2'd3, 32'h80);
        w0 = wcnt;
        ap_start(1'b1, 32'h0BAD_F00D);
        wait_idle();
        chk("R7 mode 3 writes", wcnt - w0, 32'd1);
        chk("R7 mode 3 data", wmem[32], 32'h0BAD_F00D);

        // R5 stalled target: access waits for acknowledge
        csr_wr(2'd0, 32'h0);
        csr_wr(2'd3, 32'h90);
        ack_en = 1'b0;
        w0 = wcnt;
        ap_start(1'b1, 32'h5555_AAAA);
        repeat (3) @(negedge clk);
        chk("R5 held while stalled", {31'h0, tgt_req}, 32'h1);
        chk("R5 address held", tgt_addr, 32'h90);
        chk("R5 no write before ack", wcnt - w0, 32'd0);
        ack_en = 1'b1;
        wait_idle();
        chk("R5 write after ack", wmem[36], 32'h5555_AAAA);

        // R11: requests ignored while sticky is set
        csr_wr(2'd0, 32'h1);
        csr_wr(2'd1, 32'hFFFF_FFFF);
        csr_wr(2'd3, 32'hA0);
        ap_start(1'b1, 32'h0);
        wait_idle();
        chk("R11 trigger set", {31'h0, sticky}, 32'h1);
        csr_wr(2'd0, 32'h0);
        w0 = wcnt;
        ap_start(1'b1, 32'h7777_7777);
        chk("R11 no busy while sticky", {31'h0, ap_busy}, 32'h0);
        @(negedge clk);
        chk("R11 no target write", wcnt - w0, 32'd0);
        csr_rd(2'd3, v); chk("R11 address unchanged", v, 32'hA0);
        csr_rd(2'd0, v); chk("R2 ctrl sticky bit", v, 32'h4);
        csr_wr(2'd0, 32'h4);
        chk("R11 cleared", {31'h0, sticky}, 32'h0);

        finish_run();
    end
endmodule